// File: doc/BRIEF.md
# Triggered Serial ADC Sample Capture Controller

This block takes one 16-bit sample from a serial-output ADC each time it is fired. Software first arms it, then a trigger starts a capture. The trigger is either an edge on an external pin, whose active level is set by a control bit, or a rising edge on a software strobe bit. On the trigger the block pulls its active-low convert line down. After a programmable conversion wait it toggles a serial clock and shifts in sixteen data bits. It then raises the convert line and holds the word. No further trigger is accepted until software arms it again.

The timing byte is split into two nibbles with different units, assuming a 100 MHz system clock. The upper nibble gives the conversion wait in four-cycle steps. The lower nibble gives the duration of each serial clock phase in single cycles. A nibble value of zero counts as one step. The current state code is always visible, so software can poll for completion.

Top module: `adc_capture_ctrl`

## Requirements
- R1: The state output reads 0 for waiting-for-trigger, 1 for converting, 2 for clock-low, 3 for clock-high and 4 for done. No other code ever appears.
- R2: After reset the state is done (4), the convert line is high, the serial clock is low and the data output is zero. Triggers are ignored until the block is armed.
- R3: A rising edge of control bit 0 while in done moves the state to 0 on the next clock.
- R4: While in state 0, a rising edge of control bit 1 starts a capture. The state becomes 1 and the convert line goes low on the next clock.
- R5: Control bit 7 selects the external trigger level. With 0, a rising edge starts a capture; with 1, a falling edge does. The pin passes through a two-stage synchronizer. A level held steady, or an edge in the inactive direction, starts nothing. Bit 7 does not change how the software trigger behaves.
- R6: The convert line stays low for the entire capture. With C = 4*max(timing[7:4],1), the serial clock first reads high on clock cycle C+S+1 of the low period, where S is defined in R7.
- R7: With S = max(timing[3:0],1), every clock-low and clock-high phase lasts S cycles. Exactly 16 serial clock pulses are produced per capture. The serial clock idles low and is high only while the convert line is low.
- R8: The data line is sampled as the serial clock rises, most significant bit first. The 16-bit result equals the bits presented in that order.
- R9: After the 16th high phase the state becomes done and the convert line returns high, after exactly C+32*S low cycles. The data output changes only at that moment and otherwise holds its value.
- R10: Trigger edges that arrive in done, or during a capture, are ignored. They start no capture and add no clock pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timing_i | input | 8 | [7:4] conversion wait in 4-cycle steps, [3:0] serial clock phase in cycles |
| control_i | input | 8 | [0] arm, [1] software trigger, [7] external trigger active low |
| ext_trig_i | input | 1 | External trigger pin, asynchronous |
| sdo_i | input | 1 | Serial data from the ADC |
| cnv_no | output | 1 | Convert line, active low |
| sck_o | output | 1 | Serial clock to the ADC |
| state_o | output | 3 | State code |
| data_o | output | 16 | Last captured sample |

## Verification
The hardest case to reach is a trigger that lands while a capture is already running. In that window the block is busy and the convert line is already low, so a second capture would show up only as extra clock pulses or a stretched low period. The bench fires a software strobe edge partway through selected captures. It then confirms that the low-cycle count still equals C+32*S and that exactly 16 rising edges appeared. A level-held external trigger in the active direction is also set up before arming, so that arming without a fresh edge can be shown to leave the block waiting.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [2:0] {
    ST_READY  = 3'd0,
    ST_CNV    = 3'd1,
    ST_SCK_LO = 3'd2,
    ST_SCK_HI = 3'd3,
    ST_DONE   = 3'd4
  } cap_state_e;
endpackage

// File: rtl/adc_cap_trig.sv
module adc_cap_trig #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_trig_i,
  input  logic ext_act_low_i,
  input  logic arm_lvl_i,
  input  logic soft_lvl_i,
  output logic arm_edge_o,
  output logic soft_edge_o,
  output logic ext_edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic ext_lvl, ext_lvl_q, arm_q, soft_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= ext_trig_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  // polarity applied before edge detection
  assign ext_lvl = sync_q[SYNC_STAGES-1] ^ ext_act_low_i;

  // history resets high so a level held through reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_lvl_q <= 1'b1;
      arm_q     <= 1'b1;
      soft_q    <= 1'b1;
    end else begin
      ext_lvl_q <= ext_lvl;
      arm_q     <= arm_lvl_i;
      soft_q    <= soft_lvl_i;
    end
  end

  assign ext_edge_o  = ext_lvl & ~ext_lvl_q;
  assign arm_edge_o  = arm_lvl_i & ~arm_q;
  assign soft_edge_o = soft_lvl_i & ~soft_q;
endmodule

// File: rtl/adc_cap_timer.sv
module adc_cap_timer #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_cap_shift.sv
module adc_cap_shift #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          sdo_i,
  input  logic          commit_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] sh_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      data_q <= '0;
    end else begin
      if (shift_i)  sh_q   <= {sh_q[DW-2:0], sdo_i};
      if (commit_i) data_q <= sh_q;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNV_FIELD_W = 4,
  parameter int unsigned SCK_FIELD_W = 4,
  parameter int unsigned CNV_STEP    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [CNV_FIELD_W+SCK_FIELD_W-1:0]  timing_i,
  input  logic [7:0]                          control_i,
  input  logic                                ext_trig_i,
  input  logic                                sdo_i,
  output logic                                cnv_no,
  output logic                                sck_o,
  output logic [2:0]                          state_o,
  output logic [DATA_W-1:0]                   data_o
);
  localparam int unsigned CTL_ARM  = 0;
  localparam int unsigned CTL_SOFT = 1;
  localparam int unsigned CTL_POL  = 7;
  localparam int unsigned CNV_MAX  = ((2**CNV_FIELD_W) - 1) * CNV_STEP;
  localparam int unsigned SCK_MAX  = (2**SCK_FIELD_W) - 1;
  localparam int unsigned T_MAX    = (CNV_MAX > SCK_MAX) ? CNV_MAX : SCK_MAX;
  localparam int unsigned TIMER_W  = $clog2(T_MAX + 1);
  localparam int unsigned BIT_W    = $clog2(DATA_W);

  cap_state_e state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic cnv_q, cnv_d;
  logic arm_edge, soft_edge, ext_edge, trig;
  logic t_load, t_expired, shift_en, commit;
  logic [TIMER_W-1:0] t_val, cnv_load, sck_load;
  logic [CNV_FIELD_W-1:0] cnv_field;
  logic [SCK_FIELD_W-1:0] sck_field;

  adc_cap_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ext_trig_i   (ext_trig_i),
    .ext_act_low_i(control_i[CTL_POL]),
    .arm_lvl_i    (control_i[CTL_ARM]),
    .soft_lvl_i   (control_i[CTL_SOFT]),
    .arm_edge_o   (arm_edge),
    .soft_edge_o  (soft_edge),
    .ext_edge_o   (ext_edge)
  );

  adc_cap_timer #(.W(TIMER_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (t_load),
    .load_val_i(t_val),
    .expired_o (t_expired)
  );

  adc_cap_shift #(.DW(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .sdo_i   (sdo_i),
    .commit_i(commit),
    .data_o  (data_o)
  );

  assign trig      = soft_edge | ext_edge;
  assign cnv_field = timing_i[CNV_FIELD_W+SCK_FIELD_W-1:SCK_FIELD_W];
  assign sck_field = timing_i[SCK_FIELD_W-1:0];

  // zero field counts as one step; timer holds cycles-1
  always_comb begin
    int unsigned c_steps, s_steps;
    c_steps  = (cnv_field == '0) ? 1 : int'(cnv_field);
    s_steps  = (sck_field == '0) ? 1 : int'(sck_field);
    cnv_load = TIMER_W'(c_steps * CNV_STEP - 1);
    sck_load = TIMER_W'(s_steps - 1);
  end

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    cnv_d    = cnv_q;
    t_load   = 1'b0;
    t_val    = sck_load;
    shift_en = 1'b0;
    commit   = 1'b0;
    unique case (state_q)
      ST_READY: if (trig) begin
        state_d = ST_CNV;
        cnv_d   = 1'b0;
        t_load  = 1'b1;
        t_val   = cnv_load;
      end
      ST_CNV: if (t_expired) begin
        state_d = ST_SCK_LO;
        bit_d   = '0;
        t_load  = 1'b1;
      end
      ST_SCK_LO: if (t_expired) begin
        state_d  = ST_SCK_HI;
        shift_en = 1'b1;
        t_load   = 1'b1;
      end
      ST_SCK_HI: if (t_expired) begin
        if (bit_q == BIT_W'(DATA_W - 1)) begin
          state_d = ST_DONE;
          cnv_d   = 1'b1;
          commit  = 1'b1;
        end else begin
          state_d = ST_SCK_LO;
          bit_d   = bit_q + 1'b1;
          t_load  = 1'b1;
        end
      end
      ST_DONE: if (arm_edge) state_d = ST_READY;
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_DONE;
      bit_q   <= '0;
      cnv_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      cnv_q   <= cnv_d;
    end
  end

  assign state_o = state_q;
  assign cnv_no  = cnv_q;
  assign sck_o   = (state_q == ST_SCK_HI);
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        state_i,
  input logic              cnv_ni,
  input logic              sck_i,
  input logic [DATA_W-1:0] data_i
);
  p_state_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i <= 3'd4);

  p_done_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd4) |=> (state_i == 3'd4 || state_i == 3'd0));

  p_ready_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0) |=> (state_i == 3'd0 || (state_i == 3'd1 && !cnv_ni)));

  p_cnv_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd1 || state_i == 3'd2 || state_i == 3'd3) |-> !cnv_ni);

  p_sck_in_cnv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_i |-> !cnv_ni);

  p_idle_cnv_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0 || state_i == 3'd4) |-> cnv_ni);

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != 3'd3) |=> $stable(data_i));
endmodule

bind adc_capture_ctrl adc_capture_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_i(state_o),
  .cnv_ni (cnv_no),
  .sck_i  (sck_o),
  .data_i (data_o)
);

// File: tb/sim_adc_capture_ctrl.sv
module sim_adc_capture_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] timing, control;
  logic ext_trig, sdo, cnv_n, sck;
  logic [2:0] state;
  logic [15:0] data;
  logic [15:0] word;
  int rise_cnt;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  adc_capture_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .timing_i(timing), .control_i(control),
    .ext_trig_i(ext_trig), .sdo_i(sdo), .cnv_no(cnv_n), .sck_o(sck),
    .state_o(state), .data_o(data)
  );

  // ADC model: MSB first, next bit after each sck rise
  assign sdo = (rise_cnt < 16) ? word[15 - rise_cnt] : 1'b0;
  always @(posedge sck) rise_cnt = rise_cnt + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic readout(input int kind, input bit pol, input int ct, input int st,
                         input logic [15:0] w, input bit poke);
    int c, s, lows, highs, first, n;
    c = 4 * ((ct == 0) ? 1 : ct);
    s = (st == 0) ? 1 : st;
    @(negedge clk);
    timing   = {4'(ct), 4'(st)};
    control  = {pol, 7'b0};
    ext_trig = pol;
    word     = w;
    rise_cnt = 0;
    idle_cycles(5);
    control[0] = 1'b1;
    @(negedge clk);
    chk(state == 3'd0, "R3", "state after arm", state, 0);
    control[0] = 1'b0;
    idle_cycles(2);
    if (kind == 0) control[1] = 1'b1;
    else           ext_trig = ~pol;
    lows = 0; highs = 0; first = 0; n = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      n++;
      if (kind == 0 && n == 2) control[1] = 1'b0;
      if (kind == 1 && n == 3) ext_trig = pol;
      if (poke && n == c + 5) control[1] = 1'b1;
      if (poke && n == c + 8) control[1] = 1'b0;
      if (!cnv_n) begin
        lows++;
        if (sck) begin
          highs++;
          if (first == 0) first = lows;
        end
      end
      if (state == 3'd4) break;
    end
    chk(state == 3'd4, "R9", "state after capture", state, 4);
    chk(cnv_n == 1'b1, "R9", "cnv after capture", cnv_n, 1);
    chk(lows == c + 32 * s, "R9", "cnv low cycles", lows, c + 32 * s);
    chk(first == c + s + 1, "R6", "first sck high cycle", first, c + s + 1);
    chk(highs == 16 * s, "R7", "sck high cycles", highs, 16 * s);
    chk(rise_cnt == 16, poke ? "R10" : "R7", "sck pulses", rise_cnt, 16);
    chk(data == w, "R8", "captured word", data, w);
    // triggers in done are ignored
    control[1] = 1'b1;
    ext_trig   = ~pol;
    idle_cycles(4);
    control[1] = 1'b0;
    ext_trig   = pol;
    idle_cycles(4);
    chk(state == 3'd4 && cnv_n, "R10", "state after trigger in done", state, 4);
    chk(data == w, "R10", "data held in done", data, w);
    chk(rise_cnt == 16, "R10", "no pulses in done", rise_cnt, 16);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; timing = 8'h11; control = 8'h00; ext_trig = 1'b0;
    word = 16'h0; rise_cnt = 0;
    idle_cycles(3);
    chk(state == 3'd4, "R2", "reset state", state, 4);
    chk(cnv_n == 1'b1, "R2", "reset cnv", cnv_n, 1);
    chk(sck == 1'b0, "R2", "reset sck", sck, 0);
    chk(data == 16'h0, "R2", "reset data", data, 0);
    rst_n = 1'b1;
    idle_cycles(2);
    // triggers before arming
    control[1] = 1'b1; ext_trig = 1'b1;
    idle_cycles(6);
    chk(state == 3'd4 && cnv_n, "R2", "unarmed trigger", state, 4);
    chk(rise_cnt == 0, "R2", "unarmed pulses", rise_cnt, 0);
    control[1] = 1'b0;
    idle_cycles(2);
    // active-high level held across arming: no edge, no start
    control[0] = 1'b1;
    @(negedge clk);
    control[0] = 1'b0;
    idle_cycles(6);
    chk(state == 3'd0, "R5", "held level starts nothing", state, 0);
    ext_trig = 1'b0;
    idle_cycles(6);
    chk(state == 3'd0 && cnv_n, "R5", "inactive edge starts nothing", state, 0);
    chk(state <= 3'd4, "R1", "state code range", state, 0);
    // sweep of timing fields, trigger source and polarity
    for (int ct = 0; ct < 4; ct++)
      for (int st = 0; st < 4; st++)
        readout((ct + st) % 2, ct[0], ct, st,
                16'(32'hA5C3 ^ (ct * 32'h1357) ^ (st * 32'h0F0F) ^ (ct * st * 32'h2001)),
                st == 2);
    readout(1, 1'b1, 15, 15, 16'hFFFF, 1'b1);
    readout(0, 1'b0, 15, 1, 16'h0000, 1'b0);
    readout(1, 1'b0, 1, 15, 16'h8001, 1'b0);
    readout(0, 1'b1, 7, 3, 16'h7FFE, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule